// File: doc/BRIEF.md
# Debug Command and Status Register

This block is the instruction-register path of a debug port that sits behind an IEEE 1149.1 TAP controller. The TAP controller supplies one-hot state indicators in the TCK domain. On Capture-IR a 10-bit status word, assembled from synchronized core status lines, loads into a shift stage. During Shift-IR that stage shifts out LSB first on TDO while a new 10-bit command shifts in from TDI. On Update-IR the shifted command becomes the latched command.

A latched command does nothing by itself. Its resource-access, single-step and exit strobes fire only when the next data-register scan passes Update-DR. This holds even for a step or exit command that selects no data resource. Each Update-IR arms the block for exactly one Update-DR.

An error flag records that an interrupt arrived while a stepped instruction was executing. It is reported in the status word until the next single-step is issued.

Top module: `dbg_cmd_stat`

## Requirements
- R1: On a clock edge with `st_capture_ir` high, the shift stage loads the status word. Its bit layout is: bit 0 clock-on, bit 1 error flag, bit 2 constant 0, bit 3 core-in-reset (the inverse of `core_reset_n`), bit 4 halted, bit 5 stopped, bit 6 debug mode, bit 7 waiting, bit 8 constant 0, bit 9 constant 1.
- R2: While `st_shift_ir` is high, `tdo` shows bit 0 of the shift stage. Each edge shifts the stage right by one, with `tdi` entering bit 9. After ten shifts the captured word has left on `tdo` LSB first, and the stage holds the ten `tdi` bits.
- R3: On an edge with `st_update_ir` high, the latched command takes the shift-stage contents. The fields are: bit 9 is `cmd_step`, bit 8 is `cmd_exit`, and bits 7:0 are `cmd_sel`. The select value 0xFF means no resource.
- R4: `access_stb` is high for exactly the one cycle after an edge on which `st_update_dr` is high. It fires only when an Update-IR has occurred since the last Update-DR and `cmd_sel` is not 0xFF.
- R5: Under the same Update-DR and arming condition, `step_stb` fires when `cmd_step` is 1 and `exit_stb` fires when `cmd_exit` is 1. This holds even when `cmd_sel` is 0xFF.
- R6: A second Update-DR with no Update-IR in between raises no strobe.
- R7: While `rst` is high, the latched command becomes idle: step 0, exit 0, select 0xFF. The strobes are low, the error flag clears, and the block is disarmed, so an Update-DR before any Update-IR raises no strobe.
- R8: Each core status input passes through `SYNC_STAGES` TCK flops before it is used. A change made in the same cycle as the capture is therefore not seen in that capture. A change held for three or more cycles before capture is seen.
- R9: The error flag sets when the synchronized `step_irq` is high. It stays set after `step_irq` falls. It clears on the edge that issues `step_stb`, unless `step_irq` is still high, in which case setting wins.
- R10: The debug bit follows `core_in_debug` both ways, so leaving debug mode clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | TAP clock |
| rst | input | 1 | Synchronous active-high reset (TAP test-logic-reset) |
| st_capture_ir | input | 1 | TAP is in Capture-IR |
| st_shift_ir | input | 1 | TAP is in Shift-IR |
| st_update_ir | input | 1 | TAP is in Update-IR |
| st_update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of shift stage) |
| core_clk_on | input | 1 | Core clock-running level (asynchronous) |
| core_reset_n | input | 1 | Core active-low reset level (asynchronous) |
| core_halted | input | 1 | Core halted level |
| core_stopped | input | 1 | Core stopped level |
| core_waiting | input | 1 | Core waiting level |
| core_in_debug | input | 1 | Core is in debug mode |
| step_irq | input | 1 | Interrupt taken during a single step |
| cmd_step | output | 1 | Latched command: single-step request |
| cmd_exit | output | 1 | Latched command: leave debug mode |
| cmd_sel | output | 8 | Latched command: resource select (0xFF none) |
| access_stb | output | 1 | One-cycle resource-access strobe |
| step_stb | output | 1 | One-cycle single-step strobe |
| exit_stb | output | 1 | One-cycle exit strobe |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. With this setting the synchronizer boundary can be checked in cycles. An input changed in the same cycle as Capture-IR must read as its old value, and an input held three cycles must read as its new value. With two stages the error flag has a known settling time of four cycles from `step_irq`. This allows the flag's set, hold and clear sequence to be observed through ordinary IR captures.

// File: rtl/dbgcs_pkg.sv
package dbgcs_pkg;
    localparam int IR_W     = 10;
    localparam int SEL_W    = 8;
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    // core status vector indices
    localparam int CS_CLK   = 0;
    localparam int CS_RSTN  = 1;
    localparam int CS_HALT  = 2;
    localparam int CS_STOP  = 3;
    localparam int CS_WAIT  = 4;
    localparam int CS_DBG   = 5;
    localparam int CS_IRQ   = 6;
    localparam int CS_N     = 7;

    typedef struct packed {
        logic             step;
        logic             leave;
        logic [SEL_W-1:0] sel;
    } cmd_t;

    typedef struct packed {
        logic one;
        logic zero_hi;
        logic waiting;
        logic debug;
        logic stopped;
        logic halted;
        logic in_reset;
        logic zero_lo;
        logic err;
        logic clk_on;
    } status_t;

    localparam cmd_t CMD_IDLE = '{step: 1'b0, leave: 1'b0, sel: SEL_NONE};

    function automatic status_t build_status(input logic [CS_N-1:0] cs, input logic err);
        status_t s;
        s.one      = 1'b1;
        s.zero_hi  = 1'b0;
        s.waiting  = cs[CS_WAIT];
        s.debug    = cs[CS_DBG];
        s.stopped  = cs[CS_STOP];
        s.halted   = cs[CS_HALT];
        s.in_reset = ~cs[CS_RSTN];
        s.zero_lo  = 1'b0;
        s.err      = err;
        s.clk_on   = cs[CS_CLK];
        return s;
    endfunction
endpackage

// File: rtl/dbgcs_sync.sv
module dbgcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgcs_ir_shift.sv
module dbgcs_ir_shift
    import dbgcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic            shift,
    input  logic            tdi,
    input  status_t         par_in,
    output logic [IR_W-1:0] sr,
    output logic            tdo
);
    always_ff @(posedge clk) begin
        if (rst)          sr <= '0;
        else if (capture) sr <= par_in;
        else if (shift)   sr <= {tdi, sr[IR_W-1:1]};
    end

    assign tdo = sr[0];
endmodule

// File: rtl/dbgcs_cmd_ctrl.sv
module dbgcs_cmd_ctrl
    import dbgcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic update_ir,
    input  logic update_dr,
    input  cmd_t new_cmd,
    input  logic irq_s,
    output cmd_t cmd_q,
    output logic access_stb,
    output logic step_stb,
    output logic exit_stb,
    output logic err_q
);
    logic armed;
    logic fire;

    assign fire = update_dr && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= CMD_IDLE;
            armed      <= 1'b0;
            access_stb <= 1'b0;
            step_stb   <= 1'b0;
            exit_stb   <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            access_stb <= fire && (cmd_q.sel != SEL_NONE);
            step_stb   <= fire && cmd_q.step;
            exit_stb   <= fire && cmd_q.leave;
            if (update_ir) begin
                cmd_q <= new_cmd;
                armed <= 1'b1;
            end else if (update_dr) begin
                armed <= 1'b0;
            end
            if (irq_s)                     err_q <= 1'b1;
            else if (fire && cmd_q.step)   err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_cmd_stat.sv
module dbg_cmd_stat
    import dbgcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             st_capture_ir,
    input  logic             st_shift_ir,
    input  logic             st_update_ir,
    input  logic             st_update_dr,
    input  logic             tdi,
    output logic             tdo,
    input  logic             core_clk_on,
    input  logic             core_reset_n,
    input  logic             core_halted,
    input  logic             core_stopped,
    input  logic             core_waiting,
    input  logic             core_in_debug,
    input  logic             step_irq,
    output logic             cmd_step,
    output logic             cmd_exit,
    output logic [SEL_W-1:0] cmd_sel,
    output logic             access_stb,
    output logic             step_stb,
    output logic             exit_stb
);
    logic [CS_N-1:0] cs_raw;
    logic [CS_N-1:0] cs_s;
    logic [IR_W-1:0] ir_sr;
    logic            err_q;
    cmd_t            cmd_q;
    status_t         status;

    always_comb begin
        cs_raw          = '0;
        cs_raw[CS_CLK]  = core_clk_on;
        cs_raw[CS_RSTN] = core_reset_n;
        cs_raw[CS_HALT] = core_halted;
        cs_raw[CS_STOP] = core_stopped;
        cs_raw[CS_WAIT] = core_waiting;
        cs_raw[CS_DBG]  = core_in_debug;
        cs_raw[CS_IRQ]  = step_irq;
    end

    dbgcs_sync #(.W(CS_N), .STAGES(SYNC_STAGES)) sync_i (
        .clk (tck),
        .rst (rst),
        .d   (cs_raw),
        .q   (cs_s)
    );

    assign status = build_status(cs_s, err_q);

    dbgcs_ir_shift shift_i (
        .clk     (tck),
        .rst     (rst),
        .capture (st_capture_ir),
        .shift   (st_shift_ir),
        .tdi     (tdi),
        .par_in  (status),
        .sr      (ir_sr),
        .tdo     (tdo)
    );

    dbgcs_cmd_ctrl ctrl_i (
        .clk        (tck),
        .rst        (rst),
        .update_ir  (st_update_ir),
        .update_dr  (st_update_dr),
        .new_cmd    (cmd_t'(ir_sr)),
        .irq_s      (cs_s[CS_IRQ]),
        .cmd_q      (cmd_q),
        .access_stb (access_stb),
        .step_stb   (step_stb),
        .exit_stb   (exit_stb),
        .err_q      (err_q)
    );

    assign cmd_step = cmd_q.step;
    assign cmd_exit = cmd_q.leave;
    assign cmd_sel  = cmd_q.sel;
endmodule

// File: rtl/dbg_cmd_stat_chk.sv
module dbg_cmd_stat_chk
    import dbgcs_pkg::*;
(
    input logic            tck,
    input logic            rst,
    input logic            st_capture_ir,
    input logic            st_update_ir,
    input logic            st_update_dr,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] cmd_word,
    input logic            access_stb,
    input logic            step_stb,
    input logic            exit_stb,
    input logic            err_q,
    input logic            irq_s
);
    // R1
    fixed_bits_chk: assert property (@(posedge tck) disable iff (rst)
        st_capture_ir |=> (ir_sr[9] == 1'b1 && ir_sr[8] == 1'b0 && ir_sr[2] == 1'b0));

    // R3
    cmd_latch_chk: assert property (@(posedge tck) disable iff (rst)
        st_update_ir |=> (cmd_word == $past(ir_sr)));

    // R4
    stb_after_udr_chk: assert property (@(posedge tck) disable iff (rst)
        (access_stb || step_stb || exit_stb) |-> $past(st_update_dr));

    // R4
    access_pulse_chk: assert property (@(posedge tck) disable iff (rst)
        access_stb |=> !access_stb);

    // R5
    step_pulse_chk: assert property (@(posedge tck) disable iff (rst)
        step_stb |=> !step_stb);

    // R9
    err_set_chk: assert property (@(posedge tck) disable iff (rst)
        irq_s |=> err_q);

    // R9
    err_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (err_q && !st_update_dr) |=> err_q);

    // R7
    reset_idle_chk: assert property (@(posedge tck)
        rst |=> (cmd_word == CMD_IDLE && !access_stb && !step_stb && !exit_stb && !err_q));
endmodule

bind dbg_cmd_stat dbg_cmd_stat_chk chk_i (
    .tck           (tck),
    .rst           (rst),
    .st_capture_ir (st_capture_ir),
    .st_update_ir  (st_update_ir),
    .st_update_dr  (st_update_dr),
    .ir_sr         (ir_sr),
    .cmd_word      ({cmd_step, cmd_exit, cmd_sel}),
    .access_stb    (access_stb),
    .step_stb      (step_stb),
    .exit_stb      (exit_stb),
    .err_q         (err_q),
    .irq_s         (cs_s[dbgcs_pkg::CS_IRQ])
);

// File: tb/dbg_cmd_stat_tb_top.sv
`timescale 1ns/1ps
module dbg_cmd_stat_tb_top;
    logic tck = 1'b0;
    logic rst = 1'b1;
    logic cap = 0, shf = 0, uir = 0, udr = 0, tdi = 0;
    logic tdo;
    logic clk_on = 0, rst_n = 1, halted = 0, stopped = 0, waiting = 0, in_dbg = 0, irq = 0;
    logic c_step, c_exit;
    logic [7:0] c_sel;
    logic a_stb, s_stb, e_stb;
    int n_chk = 0, n_fail = 0;

    always #10 tck = ~tck;

    dbg_cmd_stat dut_i (
        .tck(tck), .rst(rst), .st_capture_ir(cap), .st_shift_ir(shf),
        .st_update_ir(uir), .st_update_dr(udr), .tdi(tdi), .tdo(tdo),
        .core_clk_on(clk_on), .core_reset_n(rst_n), .core_halted(halted),
        .core_stopped(stopped), .core_waiting(waiting), .core_in_debug(in_dbg),
        .step_irq(irq), .cmd_step(c_step), .cmd_exit(c_exit), .cmd_sel(c_sel),
        .access_stb(a_stb), .step_stb(s_stb), .exit_stb(e_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge tck);
    endtask

    // caller is at a negedge; capture, shift ten bits, update-IR
    task automatic ir_scan(input logic [9:0] cmd, output logic [9:0] got);
        cap = 1;
        @(negedge tck);
        cap = 0;
        for (int i = 0; i < 10; i++) begin
            got[i] = tdo;
            tdi = cmd[i];
            shf = 1;
            @(negedge tck);
        end
        shf = 0;
        uir = 1;
        @(negedge tck);
        uir = 0;
    endtask

    task automatic dr_update(output logic [2:0] stb, output logic [2:0] after);
        udr = 1;
        @(negedge tck);
        udr = 0;
        stb = {a_stb, s_stb, e_stb};
        @(negedge tck);
        after = {a_stb, s_stb, e_stb};
    endtask

    task automatic t_reset;
        check("R7 cmd idle", {c_step, c_exit, c_sel}, 10'h0FF);
        check("R7 strobes low", {a_stb, s_stb, e_stb}, 3'b000);
        begin
            logic [2:0] s, a;
            dr_update(s, a);
            check("R7 no strobe before Update-IR", s, 3'b000);
        end
    endtask

    task automatic t_status;
        logic [9:0] got;
        clk_on = 1; rst_n = 0; halted = 0; stopped = 1; waiting = 1; in_dbg = 1;
        wait_cyc(3);
        ir_scan(10'h0FF, got);
        check("R1/R2 status word", got, 10'b10_1110_1001);
        clk_on = 0; rst_n = 1; halted = 1; stopped = 0; waiting = 0; in_dbg = 0;
        wait_cyc(3);
        ir_scan(10'h0FF, got);
        check("R1/R10 status word 2", got, 10'b10_0001_0000);
    endtask

    task automatic t_sync;
        logic [9:0] got;
        halted = 0;
        wait_cyc(3);
        halted = 1;
        ir_scan(10'h0FF, got);
        check("R8 same-cycle change unseen", got[4], 1'b0);
        wait_cyc(3);
        ir_scan(10'h0FF, got);
        check("R8 held change seen", got[4], 1'b1);
        in_dbg = 1;
        wait_cyc(3);
        ir_scan(10'h0FF, got);
        check("R10 debug set", got[6], 1'b1);
        in_dbg = 0;
        wait_cyc(3);
        ir_scan(10'h0FF, got);
        check("R10 debug cleared on leave", got[6], 1'b0);
        halted = 0;
    endtask

    task automatic t_cmd;
        logic [9:0] got;
        logic [2:0] s, a;
        ir_scan(10'h015, got);
        check("R3 cmd latched", {c_step, c_exit, c_sel}, 10'h015);
        check("R3 no strobe at Update-IR", {a_stb, s_stb, e_stb}, 3'b000);
        dr_update(s, a);
        check("R4 access strobe", s, 3'b100);
        check("R4 strobe one cycle", a, 3'b000);
        dr_update(s, a);
        check("R6 no repeat strobe", s, 3'b000);
        ir_scan(10'h2FF, got);
        dr_update(s, a);
        check("R5 step without resource", s, 3'b010);
        ir_scan(10'h1FF, got);
        dr_update(s, a);
        check("R5 exit without resource", s, 3'b001);
        ir_scan(10'h3A5, got);
        dr_update(s, a);
        check("R4/R5 all strobes", s, 3'b111);
        check("R4/R5 single cycle", a, 3'b000);
    endtask

    task automatic t_err;
        logic [9:0] got;
        logic [2:0] s, a;
        irq = 1;
        wait_cyc(4);
        irq = 0;
        wait_cyc(4);
        ir_scan(10'h2FF, got);
        check("R9 error set and sticky", got[1], 1'b1);
        ir_scan(10'h2FF, got);
        check("R9 error holds without step", got[1], 1'b1);
        dr_update(s, a);
        check("R9 step strobe", s[1], 1'b1);
        ir_scan(10'h0FF, got);
        check("R9 error cleared by step", got[1], 1'b0);
    endtask

    initial begin
        wait_cyc(3);
        rst = 0;
        @(negedge tck);
        t_reset();
        t_status();
        t_sync();
        t_cmd();
        t_err();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule